// File: doc/BRIEF.md
# Configurable Interrupt Pin Controller

This block merges three event sources (a watchdog expiry, an alarm match and a power failure) onto one external interrupt pin. Each event always records itself in its own sticky flag. Only a source whose enable bit is set in the control register can make the pin active. Software chooses the electrical behaviour of the pin: either push-pull active-high, or open-drain active-low, where the inactive state releases the line.

Software also chooses how long the pin stays active. In pulse mode the pin stays active for a fixed number of ticks of a 32 Hz tick-enable input. The default of seven ticks lasts about 187.5 to 218.75 ms, and a new enabled event restarts the count. In level mode the pin stays active until software reads the flags register. That read also clears every flag.

The pin is presented as a registered output-enable plus a registered data value, ready for a bidirectional pad. Every state change takes effect at the clock edge that samples its cause, so flags and pin move one cycle after an input.

Top module: `irq_pin_ctrl`

## Requirements
- R1: The control register is written with `ctl_wr`/`ctl_wdata` and read back on `ctl_rdata`. The fields are: bit 7 watchdog enable, bit 6 alarm enable, bit 5 power-fail enable, bit 2 polarity (1 = active-high), bit 1 timing (1 = pulse, 0 = level). Bits 4, 3 and 0 always read 0.
- R2: An event pulse sets its flag at the next clock edge whether or not its source is enabled. `flags_rdata` bit 2 is the watchdog flag, bit 1 the alarm flag and bit 0 the power-fail flag.
- R3: An event from a source whose enable bit is 0 never makes the pin active.
- R4: With polarity 1, `pin_oe` is 1 and `pin_do` equals the active state. With polarity 0, `pin_do` is 0 and `pin_oe` is 1 only while the pin is active.
- R5: In pulse mode, an enabled event makes the pin active from the next edge. The pin returns to inactive at the edge that samples the PULSE_TICKS-th `tick` after the most recent enabled event, so a new enabled event restarts the count. A tick in the same cycle as the event is not counted.
- R6: In level mode, an enabled event makes the pin active from the next edge. It stays active until a flags read that has no enabled event in the same cycle.
- R7: Asserting `flags_rd` for one cycle clears all flags at that edge. An event in the same cycle still sets its flag. `flags_rdata` shows the flags as they were before the clear.
- R8: After reset the control register, the flags and the timers are zero, and the pin is released (`pin_oe` = 0, `pin_do` = 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | 32 Hz tick enable, one cycle wide |
| ev_wdog | input | 1 | Watchdog expiry event pulse |
| ev_alarm | input | 1 | Alarm match event pulse |
| ev_pfail | input | 1 | Power failure event pulse |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control register write data |
| ctl_rdata | output | 8 | Control register read value |
| flags_rd | input | 1 | Flags read strobe (clears the flags) |
| flags_rdata | output | 3 | Flags: {watchdog, alarm, power-fail} |
| pin_oe | output | 1 | Interrupt pin output enable |
| pin_do | output | 1 | Interrupt pin drive value |

## Verification
The bench builds the block with PULSE_TICKS set to 4 instead of 7. This keeps pulse windows short enough that random ticks, events and reads often overlap. It also makes the last tick of a pulse collide with a restarting event, or with a mode or polarity change, many times within a few thousand cycles. Directed sequences cover the exact end of a pulse, a read that coincides with an event, and events from disabled sources under both polarities.

// File: rtl/irq_pin_pkg.sv
package irq_pin_pkg;
  localparam int NSRC = 3;
  // control register bit positions
  localparam int CB_EN_WDOG  = 7;
  localparam int CB_EN_ALARM = 6;
  localparam int CB_EN_PFAIL = 5;
  localparam int CB_POL      = 2;
  localparam int CB_PULSE    = 1;

  typedef struct packed {
    logic [NSRC-1:0] en;    // {wdog, alarm, pfail}
    logic            pol;   // 1: push-pull high, 0: open-drain low
    logic            pulse; // 1: timed pulse, 0: held level
  } ctl_t;

  function automatic logic [7:0] ctl_pack(ctl_t c);
    logic [7:0] v;
    v = '0;
    v[CB_EN_WDOG]  = c.en[2];
    v[CB_EN_ALARM] = c.en[1];
    v[CB_EN_PFAIL] = c.en[0];
    v[CB_POL]      = c.pol;
    v[CB_PULSE]    = c.pulse;
    return v;
  endfunction
endpackage

// File: rtl/irq_ctl_reg.sv
module irq_ctl_reg
  import irq_pin_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wr,
  input  logic [7:0] wdata,
  output ctl_t       ctl_q,
  output ctl_t       ctl_n
);
  always_comb begin
    ctl_n = ctl_q;
    if (wr) begin
      ctl_n.en    = {wdata[CB_EN_WDOG], wdata[CB_EN_ALARM], wdata[CB_EN_PFAIL]};
      ctl_n.pol   = wdata[CB_POL];
      ctl_n.pulse = wdata[CB_PULSE];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) ctl_q <= '0;
    else     ctl_q <= ctl_n;
  end
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] ev,
  input  logic         rd,
  output logic [N-1:0] flags_q
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)        flags_q[i] <= 1'b0;
      else if (ev[i]) flags_q[i] <= 1'b1;
      else if (rd)    flags_q[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_pulse_timer.sv
module irq_pulse_timer #(
  parameter int TICKS = 7
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic tick,
  output logic busy_n
);
  localparam int CW = $clog2(TICKS + 1);
  localparam logic [CW-1:0] LOADV = CW'(TICKS);

  logic [CW-1:0] cnt_q, cnt_n;

  always_comb begin
    cnt_n = cnt_q;
    if (load)                        cnt_n = LOADV;
    else if (tick && cnt_q != '0)    cnt_n = cnt_q - 1'b1;
  end

  assign busy_n = (cnt_n != '0);

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_n;
  end
endmodule

// File: rtl/irq_pin_encoder.sv
module irq_pin_encoder (
  input  logic clk,
  input  logic rst,
  input  logic active_n,
  input  logic pol_n,
  output logic pin_oe,
  output logic pin_do
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pin_oe <= 1'b0;
      pin_do <= 1'b0;
    end else if (pol_n) begin
      pin_oe <= 1'b1;
      pin_do <= active_n;
    end else begin
      pin_oe <= active_n;
      pin_do <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_pin_ctrl.sv
module irq_pin_ctrl
  import irq_pin_pkg::*;
#(
  parameter int PULSE_TICKS = 7
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       ev_wdog,
  input  logic       ev_alarm,
  input  logic       ev_pfail,
  input  logic       ctl_wr,
  input  logic [7:0] ctl_wdata,
  output logic [7:0] ctl_rdata,
  input  logic       flags_rd,
  output logic [2:0] flags_rdata,
  output logic       pin_oe,
  output logic       pin_do
);
  ctl_t ctl_q, ctl_n;
  logic [NSRC-1:0] ev, flags_q;
  logic trig, pulse_busy_n, lvl_q, lvl_n, active_n;

  assign ev = {ev_wdog, ev_alarm, ev_pfail};

  irq_ctl_reg u_ctl (
    .clk(clk), .rst(rst), .wr(ctl_wr), .wdata(ctl_wdata),
    .ctl_q(ctl_q), .ctl_n(ctl_n)
  );

  irq_flag_bank #(.N(NSRC)) u_flags (
    .clk(clk), .rst(rst), .ev(ev), .rd(flags_rd), .flags_q(flags_q)
  );

  assign trig = |(ev & ctl_q.en);

  irq_pulse_timer #(.TICKS(PULSE_TICKS)) u_pulse (
    .clk(clk), .rst(rst), .load(trig && ctl_q.pulse), .tick(tick),
    .busy_n(pulse_busy_n)
  );

  always_comb begin
    lvl_n = lvl_q;
    if (trig && !ctl_q.pulse) lvl_n = 1'b1;
    else if (flags_rd)        lvl_n = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) lvl_q <= 1'b0;
    else     lvl_q <= lvl_n;
  end

  assign active_n = ctl_n.pulse ? pulse_busy_n : lvl_n;

  irq_pin_encoder u_enc (
    .clk(clk), .rst(rst), .active_n(active_n), .pol_n(ctl_n.pol),
    .pin_oe(pin_oe), .pin_do(pin_do)
  );

  assign ctl_rdata   = ctl_pack(ctl_q);
  assign flags_rdata = flags_q;
endmodule

// File: rtl/irq_pin_ctrl_chk.sv
module irq_pin_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       ev_wdog,
  input logic       ev_alarm,
  input logic       ev_pfail,
  input logic       ctl_wr,
  input logic [7:0] ctl_rdata,
  input logic       flags_rd,
  input logic [2:0] flags_rdata,
  input logic       pin_oe,
  input logic       pin_do
);
  logic act;
  assign act = ctl_rdata[2] ? pin_do : pin_oe;

  assert_ctl_zero_R1: assert property (@(posedge clk) disable iff (rst)
    (ctl_rdata[4:3] == 2'b00) && (ctl_rdata[0] == 1'b0));

  assert_flag_set_R2: assert property (@(posedge clk) disable iff (rst)
    ev_wdog |=> flags_rdata[2]);

  assert_flag_set_alarm_R2: assert property (@(posedge clk) disable iff (rst)
    ev_alarm |=> flags_rdata[1]);

  assert_disabled_quiet_R3: assert property (@(posedge clk) disable iff (rst)
    (ctl_rdata[7:5] == 3'b000 && !ctl_wr && !act) |=> !act);

  assert_od_low_R4: assert property (@(posedge clk) disable iff (rst)
    !ctl_rdata[2] |-> !pin_do);

  assert_pp_drive_R4: assert property (@(posedge clk) disable iff (rst)
    ctl_rdata[2] |-> pin_oe);

  assert_read_clear_R7: assert property (@(posedge clk) disable iff (rst)
    (flags_rd && !ev_wdog && !ev_alarm && !ev_pfail) |=> (flags_rdata == 3'b000));

  assert_reset_state_R8: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (flags_rdata == 3'b000 && ctl_rdata == 8'h00 && !pin_oe));
endmodule

bind irq_pin_ctrl irq_pin_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .ev_wdog(ev_wdog), .ev_alarm(ev_alarm),
  .ev_pfail(ev_pfail), .ctl_wr(ctl_wr), .ctl_rdata(ctl_rdata),
  .flags_rd(flags_rd), .flags_rdata(flags_rdata),
  .pin_oe(pin_oe), .pin_do(pin_do)
);

// File: tb/tb_irq_pin_ctrl.sv
module tb_irq_pin_ctrl;
  localparam int P = 4;

  logic clk = 1'b0, rst = 1'b1;
  logic tick = 0, ev_wdog = 0, ev_alarm = 0, ev_pfail = 0;
  logic ctl_wr = 0, flags_rd = 0;
  logic [7:0] ctl_wdata = 0;
  logic [7:0] ctl_rdata;
  logic [2:0] flags_rdata;
  logic pin_oe, pin_do;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;

  // reference state, built from the requirements
  logic [2:0] m_en = 0, m_flags = 0;
  logic m_pol = 0, m_pm = 0, m_lvl = 0;
  int m_cnt = 0;

  always #4 clk = ~clk;

  irq_pin_ctrl #(.PULSE_TICKS(P)) dut (
    .clk(clk), .rst(rst), .tick(tick), .ev_wdog(ev_wdog), .ev_alarm(ev_alarm),
    .ev_pfail(ev_pfail), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .ctl_rdata(ctl_rdata), .flags_rd(flags_rd), .flags_rdata(flags_rdata),
    .pin_oe(pin_oe), .pin_do(pin_do)
  );

  always @(posedge clk) begin
    logic [2:0] ev;
    logic trig;
    cyc++;
    ev = {ev_wdog, ev_alarm, ev_pfail};
    if (rst) begin
      m_en = 0; m_flags = 0; m_pol = 0; m_pm = 0; m_lvl = 0; m_cnt = 0;
    end else begin
      trig = |(ev & m_en);
      if (trig && m_pm) m_cnt = P;
      else if (tick && m_cnt != 0) m_cnt = m_cnt - 1;
      if (trig && !m_pm) m_lvl = 1;
      else if (flags_rd) m_lvl = 0;
      m_flags = (flags_rd ? 3'b000 : m_flags) | ev;
      if (ctl_wr) begin
        m_en = ctl_wdata[7:5]; m_pol = ctl_wdata[2]; m_pm = ctl_wdata[1];
      end
    end
  end

  function automatic logic exp_active();
    return m_pm ? (m_cnt != 0) : m_lvl;
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic check_all();
    logic a;
    a = exp_active();
    chk("R1 ctl_rdata", ctl_rdata, {m_en, 2'b00, m_pol, m_pm, 1'b0});
    chk("R2/R7 flags", {5'b0, flags_rdata}, {5'b0, m_flags});
    chk(m_pm ? "R5/R4 pin" : "R6/R4 pin", {6'b0, pin_oe, pin_do},
        {6'b0, (m_pol ? 1'b1 : a), (m_pol ? a : 1'b0)});
  endtask

  // one cycle: inputs applied at negedge, outputs checked at next negedge
  task automatic step(logic [2:0] ev, logic t, logic rd, logic wr, logic [7:0] wd);
    {ev_wdog, ev_alarm, ev_pfail} = ev;
    tick = t; flags_rd = rd; ctl_wr = wr; ctl_wdata = wd;
    @(negedge clk);
    {ev_wdog, ev_alarm, ev_pfail} = 0;
    tick = 0; flags_rd = 0; ctl_wr = 0;
    check_all();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R8: reset state
    chk("R8 ctl", ctl_rdata, 8'h00);
    chk("R8 flags", {5'b0, flags_rdata}, 8'h00);
    chk("R8 pin", {6'b0, pin_oe, pin_do}, 8'h00);

    // R1: unused bits read zero
    step(0, 0, 0, 1, 8'hFF);
    chk("R1 readback", ctl_rdata, 8'hE6);

    // R3: disabled sources, push-pull, pulse mode
    step(0, 0, 0, 1, 8'h06);
    step(3'b111, 0, 0, 0, 0);
    chk("R3 pin idle pp", {6'b0, pin_oe, pin_do}, 8'h02);
    chk("R2 all flags", {5'b0, flags_rdata}, 8'h07);
    // R7: read clears, simultaneous alarm event survives
    step(3'b010, 0, 1, 0, 0);
    chk("R7 clear keeps new", {5'b0, flags_rdata}, 8'h02);
    step(0, 0, 1, 0, 0);
    chk("R7 cleared", {5'b0, flags_rdata}, 8'h00);

    // R5: exact pulse length with watchdog enabled, active-high
    step(0, 0, 0, 1, 8'h86);
    step(3'b100, 1, 0, 0, 0);      // same-cycle tick not counted
    for (int k = 0; k < P - 1; k++) step(0, 1, 0, 0, 0);
    chk("R5 still active", {7'b0, pin_do}, 8'h01);
    step(0, 1, 0, 0, 0);
    chk("R5 ended", {7'b0, pin_do}, 8'h00);
    // R5: restart during pulse
    step(3'b100, 0, 0, 0, 0);
    step(0, 1, 0, 0, 0); step(0, 1, 0, 0, 0);
    step(3'b100, 0, 0, 0, 0);
    for (int k = 0; k < P - 1; k++) step(0, 1, 0, 0, 0);
    chk("R5 restarted", {7'b0, pin_do}, 8'h01);
    step(0, 1, 0, 0, 0);

    // R6: level mode, open-drain, alarm enabled
    step(0, 0, 1, 1, 8'h40);
    step(3'b010, 0, 0, 0, 0);
    idle(5);
    chk("R6 held", {6'b0, pin_oe, pin_do}, 8'h02);
    step(3'b010, 0, 1, 0, 0);      // event beats read
    chk("R6 event beats read", {6'b0, pin_oe, pin_do}, 8'h02);
    step(0, 0, 1, 0, 0);
    chk("R6 released", {6'b0, pin_oe, pin_do}, 8'h00);
    // R3: disabled sources, open-drain
    step(3'b101, 0, 0, 0, 0);
    chk("R3 pin idle od", {6'b0, pin_oe, pin_do}, 8'h00);

    // constrained random phase, fixed seed
    void'($urandom(32'd1234));
    for (int i = 0; i < 4000; i++) begin
      logic [2:0] ev;
      logic [7:0] wd;
      ev = '0;
      for (int s = 0; s < 3; s++) ev[s] = ($urandom % 16) == 0;
      wd = 8'($urandom);
      step(ev, ($urandom % 4) == 0, ($urandom % 12) == 0, ($urandom % 40) == 0, wd);
    end

    // R8: reset in the middle of activity
    step(0, 0, 0, 1, 8'hE6);
    step(3'b111, 0, 0, 0, 0);
    rst = 1;
    @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R8 re-reset flags", {5'b0, flags_rdata}, 8'h00);
    chk("R8 re-reset pin", {6'b0, pin_oe, pin_do}, 8'h00);
    done = 1;
  end

  initial begin
    while (!done && cyc < 50000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule